// File: doc/BRIEF.md
# Interrupt-Forced Peripheral Bus Ready

This block decides whether a CPU access to an internal peripheral bus may finish in the current cycle. The bus sits in front of FIFOs. A write to a full FIFO or a read from an empty FIFO is not ready, and the CPU stalls for as long as that stays true.

A two-bit mode field taken from the processor status word arms a recovery path. When the field holds the enable code, a falling edge on the active-low non-maskable interrupt pin raises a grant. The grant forces the bus ready, so a stalled access can complete whatever the FIFO flags say. The grant then clears on the first clock edge at which an access is presented.

A synchronous software-reset input drops the grant, releases any stall and discards an interrupt edge that is still in the synchronizer. The block is meant to be used with a communication-port software reset, to recover from a hung port.

Top module: `periph_grant_ctrl`

## Requirements
- R1: The forced-grant mode is enabled only when `mode_i` equals 2'b10. The values 2'b00, 2'b01 and 2'b11 leave it disabled.
- R2: With the mode enabled, a high-to-low transition on `irq_ni` passes through a two-flop synchronizer and an edge detector. `grant_o` rises at the third rising clock edge after the low level is first sampled.
- R3: A request with `req_write_i`=1 while `fifo_full_i`=1 is not ready. Unless a grant or a software reset is active, `ready_o`=0 and `stall_o`=1.
- R4: A request with `req_write_i`=0 while `fifo_empty_i`=1 is not ready. Unless a grant or a software reset is active, `ready_o`=0 and `stall_o`=1.
- R5: With the mode disabled, an interrupt edge has no effect. `grant_o` stays 0 and a stalled access stays stalled.
- R6: While `grant_o`=1, `ready_o`=1 and `stall_o`=0, whatever the FIFO flags are.
- R7: Once set, the grant holds through idle cycles. It clears at the first rising edge at which `req_valid_i`=1. If a new qualified edge arrives in that same cycle, the grant stays set.
- R8: While `sw_rst_i`=1, `ready_o`=1 and `stall_o`=0. At the next edge `grant_o` is cleared, and an interrupt edge still in the synchronizer is discarded.
- R9: After the asynchronous reset `rst_ni`, `grant_o`=0, and with no request `ready_o`=1 and `stall_o`=0.
- R10: With `req_valid_i`=0, `stall_o`=0 and `ready_o`=1. A rising edge of `irq_ni` never raises a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_rst_i | input | 1 | Synchronous software reset of the grant and stall state |
| mode_i | input | 2 | Forced-grant mode field from the status word |
| irq_ni | input | 1 | Non-maskable interrupt, active low, asynchronous |
| req_valid_i | input | 1 | CPU peripheral-bus access present |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| fifo_full_i | input | 1 | Target FIFO full |
| fifo_empty_i | input | 1 | Target FIFO empty |
| ready_o | output | 1 | Access may complete this cycle |
| stall_o | output | 1 | Access present and not ready |
| grant_o | output | 1 | Forced grant active |

## Verification
The hardest case to reach is an interrupt edge that is still inside the synchronizer when something else changes. The bench pulls `irq_ni` low and then, one cycle later, either pulses `sw_rst_i` or switches `mode_i` away from the enable code. It then checks that no grant appears. A second hard case is a grant that must survive idle cycles and then clear exactly at the cycle of a stalled read. The bench reaches it by holding the request off for several cycles after the edge and then presenting a read to an empty FIFO.

// File: rtl/periph_grant_pkg.sv
package periph_grant_pkg;
  localparam int unsigned MODE_W = 2;
  localparam logic [MODE_W-1:0] FORCE_MODE_CODE = 2'b10;

  typedef struct packed {
    logic valid;
    logic write;
  } pbus_acc_t;

  function automatic logic acc_blocked(pbus_acc_t acc, logic full, logic empty);
    return acc.valid & (acc.write ? full : empty);
  endfunction
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q[g] <= RST_VAL;
      end else if (clr_i) begin
        // preload with the live pin value so no edge spans the clear
        chain_q[g] <= d_i;
      end else begin
        chain_q[g] <= (g == 0) ? d_i : chain_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pg_grant_gen.sv
module pg_grant_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic irq_raw_ni,
  input  logic irq_sync_ni,
  input  logic mode_en_i,
  input  logic acc_done_i,
  output logic grant_o
);
  logic irq_prev_q;
  logic fall_det;
  logic grant_q;

  assign fall_det = irq_prev_q & ~irq_sync_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_prev_q <= 1'b1;
    end else if (clr_i) begin
      irq_prev_q <= irq_raw_ni;
    end else begin
      irq_prev_q <= irq_sync_ni;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= 1'b0;
    end else if (clr_i) begin
      grant_q <= 1'b0;
    end else if (fall_det && mode_en_i) begin
      grant_q <= 1'b1;
    end else if (acc_done_i) begin
      grant_q <= 1'b0;
    end
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/pg_ready_eval.sv
module pg_ready_eval
  import periph_grant_pkg::*;
(
  input  pbus_acc_t acc_i,
  input  logic      fifo_full_i,
  input  logic      fifo_empty_i,
  input  logic      grant_i,
  input  logic      clr_i,
  output logic      ready_o,
  output logic      stall_o
);
  logic blocked;

  always_comb begin
    blocked = acc_blocked(acc_i, fifo_full_i, fifo_empty_i);
    ready_o = ~blocked | grant_i | clr_i;
    stall_o = acc_i.valid & ~ready_o;
  end
endmodule

// File: rtl/periph_grant_ctrl.sv
module periph_grant_ctrl
  import periph_grant_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_rst_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              irq_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              fifo_full_i,
  input  logic              fifo_empty_i,
  output logic              ready_o,
  output logic              stall_o,
  output logic              grant_o
);
  logic      irq_sync_n;
  logic      mode_en;
  logic      grant;
  pbus_acc_t acc;

  assign mode_en = (mode_i == FORCE_MODE_CODE);
  assign acc     = '{valid: req_valid_i, write: req_write_i};

  pg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_irq_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sw_rst_i),
    .d_i    (irq_ni),
    .q_o    (irq_sync_n)
  );

  pg_grant_gen u_grant (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (sw_rst_i),
    .irq_raw_ni  (irq_ni),
    .irq_sync_ni (irq_sync_n),
    .mode_en_i   (mode_en),
    .acc_done_i  (req_valid_i),
    .grant_o     (grant)
  );

  pg_ready_eval u_ready (
    .acc_i        (acc),
    .fifo_full_i  (fifo_full_i),
    .fifo_empty_i (fifo_empty_i),
    .grant_i      (grant),
    .clr_i        (sw_rst_i),
    .ready_o      (ready_o),
    .stall_o      (stall_o)
  );

  assign grant_o = grant;
endmodule

// File: rtl/periph_grant_ctrl_chk.sv
module periph_grant_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sw_rst_i,
  input logic [1:0] mode_i,
  input logic       req_valid_i,
  input logic       req_write_i,
  input logic       fifo_full_i,
  input logic       fifo_empty_i,
  input logic       ready_o,
  input logic       stall_o,
  input logic       grant_o
);
  AST_GRANT_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> $past(mode_i) == 2'b10); // R1
  AST_WRITE_FULL_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && fifo_full_i && !grant_o && !sw_rst_i) |-> stall_o); // R3
  AST_READ_EMPTY_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && fifo_empty_i && !grant_o && !sw_rst_i) |-> stall_o); // R4
  AST_GRANT_FORCES_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (ready_o && !stall_o)); // R6
  AST_GRANT_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !req_valid_i && !sw_rst_i) |=> grant_o); // R7
  AST_SWRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> !grant_o); // R8
  AST_SWRST_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |-> !stall_o); // R8
  AST_STALL_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> req_valid_i); // R10
endmodule

bind periph_grant_ctrl periph_grant_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sw_rst_i     (sw_rst_i),
  .mode_i       (mode_i),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .fifo_full_i  (fifo_full_i),
  .fifo_empty_i (fifo_empty_i),
  .ready_o      (ready_o),
  .stall_o      (stall_o),
  .grant_o      (grant_o)
);

// File: tb/periph_grant_ctrl_tb.sv
module periph_grant_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sw_rst = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       irq_n = 1'b1;
  logic       req_v = 1'b0;
  logic       req_w = 1'b0;
  logic       full = 1'b0;
  logic       empty = 1'b0;
  logic       ready, stall, grant;

  int    n_checks = 0;
  int    n_errors = 0;
  int    cycles = 0;
  string tag = "R9";

  // reference model state
  bit irq_hist[$];
  bit m_grant = 1'b0;

  always #5 clk = ~clk;

  periph_grant_ctrl u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .sw_rst_i     (sw_rst),
    .mode_i       (mode),
    .irq_ni       (irq_n),
    .req_valid_i  (req_v),
    .req_write_i  (req_w),
    .fifo_full_i  (full),
    .fifo_empty_i (empty),
    .ready_o      (ready),
    .stall_o      (stall),
    .grant_o      (grant)
  );

  function automatic void hist_fill(bit v);
    irq_hist.delete();
    for (int i = 0; i < 4; i++) irq_hist.push_back(v);
  endfunction

  initial hist_fill(1'b1);

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_grant = 1'b0;
      hist_fill(1'b1);
    end else if (sw_rst) begin
      m_grant = 1'b0;
      hist_fill(irq_n);
    end else begin
      // qualified edge: sample three edges back high, two edges back low
      if (irq_hist[irq_hist.size()-3] && !irq_hist[irq_hist.size()-2] && mode == 2'b10)
        m_grant = 1'b1;
      else if (req_v)
        m_grant = 1'b0;
      irq_hist.push_back(irq_n);
      void'(irq_hist.pop_front());
    end
  end

  task automatic check(string t, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", t, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    bit blocked, m_ready;
    cycles++;
    if (rst_ni) begin
      blocked = req_v && (req_w ? full : empty);
      m_ready = !blocked || m_grant || sw_rst;
      check(tag, "grant_o", grant, m_grant);
      check(tag, "ready_o", ready, m_ready);
      check(tag, "stall_o", stall, req_v && !m_ready);
    end
    if (cycles > 5000) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic irq_fall_rise(int low_cycles);
    irq_n = 1'b0;
    step(low_cycles);
    irq_n = 1'b1;
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    tag = "R9"; step(3);
    tag = "R10"; req_v = 0; full = 1; empty = 1; step(3);

    tag = "R3"; req_v = 1; req_w = 1; full = 1; empty = 0; step(4);
    check("R3", "stall write-full", stall, 1'b1);
    tag = "R4"; req_w = 0; full = 0; empty = 1; step(4);
    check("R4", "stall read-empty", stall, 1'b1);
    req_w = 1; step(2); // write to non-full: ready

    tag = "R5"; req_v = 1; req_w = 0; empty = 1; mode = 2'b00;
    irq_fall_rise(5); step(5);
    check("R5", "still stalled", stall, 1'b1);
    tag = "R1"; mode = 2'b01; irq_fall_rise(5); step(5);
    mode = 2'b11; irq_fall_rise(5); step(5);
    check("R1", "no grant for 11", grant, 1'b0);

    tag = "R2"; req_v = 0; mode = 2'b10;
    irq_n = 1'b0; step(2);
    check("R2", "no grant before 3rd edge", grant, 1'b0);
    step(1);
    check("R2", "grant at 3rd edge", grant, 1'b1);
    tag = "R7"; step(6);
    check("R7", "grant held idle", grant, 1'b1);
    tag = "R6"; req_v = 1; req_w = 0; empty = 1; full = 1;
    #3; check("R6", "ready forced", ready, 1'b1);
    step(1);
    tag = "R7"; check("R7", "grant cleared after access", grant, 1'b0);
    check("R7", "stall back", stall, 1'b1);
    irq_n = 1'b1; req_v = 0; step(4);

    tag = "R10"; irq_n = 1'b0; step(4); irq_n = 1'b1; step(2);
    req_v = 1; step(1); req_v = 0;
    step(5);
    check("R10", "no grant from rising edge", grant, 1'b0);

    tag = "R8"; req_v = 1; req_w = 1; full = 1;
    irq_n = 1'b0; step(1); sw_rst = 1; #2;
    check("R8", "no stall in sw reset", stall, 1'b0);
    step(1); sw_rst = 0; step(6);
    check("R8", "edge discarded", grant, 1'b0);
    irq_n = 1'b1; step(3);

    tag = "R8"; req_v = 0; irq_fall_rise(5); step(1);
    sw_rst = 1; step(1); sw_rst = 0; #2;
    check("R8", "grant cleared", grant, 1'b0);
    step(2);

    tag = "R1"; irq_n = 1'b0; step(1); mode = 2'b11; step(4);
    check("R1", "mode dropped mid-sync", grant, 1'b0);
    irq_n = 1'b1; mode = 2'b10; step(3);

    tag = "R7"; req_v = 1; req_w = 0; empty = 1;
    irq_n = 1'b0; step(6); irq_n = 1'b1; step(1);
    irq_n = 1'b0; step(6); irq_n = 1'b1; step(4);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule